// File: doc/BRIEF.md
# Frame and Code Sync Generator

This block produces the timing references for a telemetry converter test rig. It counts a single system clock and emits a long, low-duty frame sync pulse. It also emits a one-cycle frame-start strobe that other logic can use to align to the frame. Inside every frame it emits two grouped code-sync pulse trains. The instruction train has sixteen groups. The computer-word train has four groups, and its first group is locked to the last group of the instruction train.

With the defaults, the 10 MHz clock gives a 25 ms frame (250000 cycles) and a 25 µs sync pulse (250 cycles). Every code pulse lasts eight cycles per bit at 50% duty, with eight bits per group. The instruction train begins a set number of cycles after the frame pulse falls. All timing values are parameters.

Generation starts by itself when reset is released. A stop request silences the outputs. A later run request starts a fresh frame.

Top module: `tsync_gen`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), all four outputs are 0.
- R2: After reset, the first clock edge with `rst_n` high drives `frame_sync_o` to 1. It stays high for SYNC_HIGH cycles and repeats every FRAME_CYCLES cycles while running.
- R3: `frame_start_o` is high for exactly one cycle per frame, in the first cycle that `frame_sync_o` is high.
- R4: `in_sync_o` rises for the first time SYNC_HIGH+IN_DELAY cycles after the frame-start cycle. It gives IN_GROUPS×BITS_PER_GROUP rising edges per frame.
- R5: Each code bit of either train is high for BIT_HIGH cycles out of every BIT_CYCLES. A group holds BITS_PER_GROUP bits, and groups start GROUP_CYCLES apart.
- R6: The first computer-word pulse on `cw_sync_o` rises on the same cycle as the first pulse of the last instruction group. The train gives CW_GROUPS×BITS_PER_GROUP rising edges per frame.
- R7: A cycle with `stop_i` high drives every output to 0 at the next edge. The outputs stay 0 until a restart.
- R8: When stopped, a `run_i` pulse sampled at edge e restarts the frame counter. `frame_sync_o` and `frame_start_o` then rise at edge e+1.
- R9: `run_i` while already running has no effect on the frame phase; the frame period stays FRAME_CYCLES.
- R10: When `stop_i` and `run_i` are both high, stop wins.
- R11: Neither code-sync output is ever high while `frame_sync_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Start request, used only when stopped |
| stop_i | input | 1 | Stop request, has priority |
| frame_sync_o | output | 1 | Frame sync pulse |
| frame_start_o | output | 1 | One-cycle strobe on frame sync rise |
| cw_sync_o | output | 1 | Computer-word code-sync train |
| in_sync_o | output | 1 | Instruction code-sync train |

## Verification
Four properties are checked on every cycle:
- the frame-start strobe only ever marks a frame-sync rise;
- a stop silences every output at the next edge;
- the code trains never overlap the frame pulse;
- the first computer-word group starts together with the last instruction group.

Some behaviour only the bench scenarios can show. This covers the exact offsets, periods and pulse counts across a whole frame, and the restart latency after a run. It also covers the stop-over-run priority and the fact that a run while running leaves the phase alone. The bench shows these by comparing against a frame-phase model under random run and stop traffic, and by measuring edges directly.

// File: rtl/tsync_pkg.sv
// Package: shared types and width helper for the sync generator.
// Assumes: nothing beyond IEEE 1800-2017.
package tsync_pkg;
    typedef enum logic {
        SYNC_HALT = 1'b0,
        SYNC_RUN  = 1'b1
    } sync_state_e;

    // Counter width able to hold values 0..n-1, never below one bit.
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/tsync_frame_timer.sv
// Module: frame phase counter with run/stop control and frame sync outputs.
// Assumes: SYNC_HIGH < FRAME_CYCLES; stop_i has priority over run_i;
// run_i only matters while halted. active_o is high when the counter will
// keep running at this edge, so downstream registers can gate on it.
module tsync_frame_timer #(
    parameter int FRAME_CYCLES = 250000,
    parameter int SYNC_HIGH    = 250,
    parameter int CNT_W        = tsync_pkg::cnt_width(FRAME_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             stop_i,
    output logic             active_o,
    output logic [CNT_W-1:0] phase_o,
    output logic             fsync_o,
    output logic             fstart_o
);
    import tsync_pkg::*;

    localparam logic [CNT_W-1:0] PH_LAST  = CNT_W'(FRAME_CYCLES - 1);
    localparam logic [CNT_W-1:0] HIGH_END = CNT_W'(SYNC_HIGH);

    sync_state_e      state_q;
    logic [CNT_W-1:0] phase_q;

    // Running and not being stopped on this edge.
    assign active_o = (state_q == SYNC_RUN) && !stop_i;
    assign phase_o  = phase_q;

    // Run state and frame phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SYNC_RUN;
            phase_q <= '0;
        end else if (stop_i) begin
            state_q <= SYNC_HALT;
            phase_q <= '0;
        end else if (run_i && state_q == SYNC_HALT) begin
            state_q <= SYNC_RUN;
            phase_q <= '0;
        end else if (state_q == SYNC_RUN) begin
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
        end
    end

    // Registered frame sync and frame-start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsync_o  <= 1'b0;
            fstart_o <= 1'b0;
        end else begin
            fsync_o  <= active_o && (phase_q < HIGH_END);
            fstart_o <= active_o && (phase_q == '0);
        end
    end

    // R3: the strobe marks only the rising cycle of frame sync.
    a_r3_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        fstart_o |-> (fsync_o && !$past(fsync_o)));
endmodule

// File: rtl/tsync_burst_train.sv
// Module: one grouped code-sync train inside the frame.
// Assumes: START >= 1 and the whole train ends before the frame wraps.
// GROUP_CYCLES > BITS*BIT_CYCLES, and BIT_HIGH < BIT_CYCLES.
// The internal state describes the phase the frame counter holds now.
// The output is registered from it, so it lines up with frame sync.
module tsync_burst_train #(
    parameter int CNT_W        = 18,
    parameter int START        = 350,
    parameter int GROUPS       = 16,
    parameter int GROUP_CYCLES = 128,
    parameter int BITS         = 8,
    parameter int BIT_CYCLES   = 8,
    parameter int BIT_HIGH     = 4,
    parameter int GW           = tsync_pkg::cnt_width(GROUPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [CNT_W-1:0] phase_i,
    output logic             pulse_o,
    output logic             first_o,
    output logic [GW-1:0]    grp_o
);
    import tsync_pkg::*;

    localparam int PW = cnt_width(GROUP_CYCLES);
    localparam int BW = cnt_width(BIT_CYCLES);

    localparam logic [CNT_W-1:0] TRIG      = CNT_W'(START - 1);
    localparam logic [PW-1:0]    PH_LAST   = PW'(GROUP_CYCLES - 1);
    localparam logic [PW:0]      BURST_LEN = (PW+1)'(BITS * BIT_CYCLES);
    localparam logic [BW-1:0]    BP_LAST   = BW'(BIT_CYCLES - 1);
    localparam logic [BW:0]      HIGH_LEN  = (BW+1)'(BIT_HIGH);
    localparam logic [GW-1:0]    GRP_LAST  = GW'(GROUPS - 1);

    logic          busy_q;
    logic [PW-1:0] ph_q;
    logic [BW-1:0] bp_q;
    logic [GW-1:0] grp_q;
    logic          burst_on;

    // Position decode: inside the bit part of a group and in the high half.
    always_comb begin
        burst_on = busy_q && ({1'b0, ph_q} < BURST_LEN) && ({1'b0, bp_q} < HIGH_LEN);
    end

    // Group, in-group and in-bit counters, armed one cycle before START.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ph_q   <= '0;
            bp_q   <= '0;
            grp_q  <= '0;
        end else if (!active_i) begin
            busy_q <= 1'b0;
            ph_q   <= '0;
            bp_q   <= '0;
            grp_q  <= '0;
        end else if (phase_i == TRIG) begin
            busy_q <= 1'b1;
            ph_q   <= '0;
            bp_q   <= '0;
            grp_q  <= '0;
        end else if (busy_q) begin
            if (ph_q == PH_LAST) begin
                ph_q <= '0;
                bp_q <= '0;
                if (grp_q == GRP_LAST) begin
                    busy_q <= 1'b0;
                    grp_q  <= '0;
                end else begin
                    grp_q <= grp_q + 1'b1;
                end
            end else begin
                ph_q <= ph_q + 1'b1;
                bp_q <= (bp_q == BP_LAST) ? '0 : bp_q + 1'b1;
            end
        end
    end

    // Registered, glitch-free pulse output.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_o <= 1'b0;
        else        pulse_o <= active_i && burst_on;
    end

    assign first_o = busy_q && (ph_q == '0);
    assign grp_o   = grp_q;

    // R5: a pulse that starts while running lasts beyond one cycle when BIT_HIGH > 1.
    a_r5_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pulse_o) && active_i && (BIT_HIGH > 1)) |=> pulse_o);
endmodule

// File: rtl/tsync_gen.sv
// Module: top of the frame and code sync generator.
// Assumes: the instruction train starts IN_DELAY cycles after frame sync falls.
// The computer-word train starts on the first cycle of the last instruction
// group, and both trains end before the frame wraps.
module tsync_gen #(
    parameter int FRAME_CYCLES   = 250000,
    parameter int SYNC_HIGH      = 250,
    parameter int IN_DELAY       = 100,
    parameter int IN_GROUPS      = 16,
    parameter int CW_GROUPS      = 4,
    parameter int GROUP_CYCLES   = 128,
    parameter int BITS_PER_GROUP = 8,
    parameter int BIT_CYCLES     = 8,
    parameter int BIT_HIGH       = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic stop_i,
    output logic frame_sync_o,
    output logic frame_start_o,
    output logic cw_sync_o,
    output logic in_sync_o
);
    import tsync_pkg::*;

    localparam int CNT_W    = cnt_width(FRAME_CYCLES);
    localparam int IN_START = SYNC_HIGH + IN_DELAY;
    localparam int CW_START = IN_START + (IN_GROUPS - 1) * GROUP_CYCLES;
    localparam int IN_GW    = cnt_width(IN_GROUPS);
    localparam int CW_GW    = cnt_width(CW_GROUPS);
    localparam logic [IN_GW-1:0] IN_GRP_LAST = IN_GW'(IN_GROUPS - 1);

    logic             active;
    logic [CNT_W-1:0] phase;
    logic             in_first, cw_first;
    logic [IN_GW-1:0] in_grp;
    logic [CW_GW-1:0] cw_grp;

    tsync_frame_timer #(
        .FRAME_CYCLES(FRAME_CYCLES),
        .SYNC_HIGH   (SYNC_HIGH),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_i),
        .stop_i  (stop_i),
        .active_o(active),
        .phase_o (phase),
        .fsync_o (frame_sync_o),
        .fstart_o(frame_start_o)
    );

    tsync_burst_train #(
        .CNT_W(CNT_W), .START(IN_START), .GROUPS(IN_GROUPS),
        .GROUP_CYCLES(GROUP_CYCLES), .BITS(BITS_PER_GROUP),
        .BIT_CYCLES(BIT_CYCLES), .BIT_HIGH(BIT_HIGH), .GW(IN_GW)
    ) u_in_train (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .phase_i (phase),
        .pulse_o (in_sync_o),
        .first_o (in_first),
        .grp_o   (in_grp)
    );

    tsync_burst_train #(
        .CNT_W(CNT_W), .START(CW_START), .GROUPS(CW_GROUPS),
        .GROUP_CYCLES(GROUP_CYCLES), .BITS(BITS_PER_GROUP),
        .BIT_CYCLES(BIT_CYCLES), .BIT_HIGH(BIT_HIGH), .GW(CW_GW)
    ) u_cw_train (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .phase_i (phase),
        .pulse_o (cw_sync_o),
        .first_o (cw_first),
        .grp_o   (cw_grp)
    );

    // R6: first computer-word group opens with the last instruction group.
    a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_first && cw_grp == '0) |-> (in_first && in_grp == IN_GRP_LAST));

    // R7: a stop request silences every output at the next edge.
    a_r7_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !(frame_sync_o || frame_start_o || cw_sync_o || in_sync_o));

    // R11: code trains stay clear of the frame pulse.
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync_o |-> !(cw_sync_o || in_sync_o));
endmodule

// File: tb/tsync_gen_test.sv
module tsync_gen_test;
    localparam int FR   = 3000;
    localparam int SH   = 50;
    localparam int DLY  = 30;
    localparam int ING  = 16;
    localparam int CWG  = 4;
    localparam int GP   = 128;
    localparam int BITS = 8;
    localparam int BC   = 8;
    localparam int BH   = 4;
    localparam int IN_ST = SH + DLY;
    localparam int CW_ST = IN_ST + (ING - 1) * GP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 1'b0;
    logic stop_i = 1'b0;
    logic frame_sync_o, frame_start_o, cw_sync_o, in_sync_o;

    int checks = 0;
    int errors = 0;

    // Model state.
    bit mrun = 1'b1;
    int mp = 0;
    bit e_fs, e_st, e_in, e_cw;

    always #2.5 clk = ~clk;

    tsync_gen #(
        .FRAME_CYCLES(FR), .SYNC_HIGH(SH), .IN_DELAY(DLY),
        .IN_GROUPS(ING), .CW_GROUPS(CWG), .GROUP_CYCLES(GP),
        .BITS_PER_GROUP(BITS), .BIT_CYCLES(BC), .BIT_HIGH(BH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .stop_i(stop_i),
        .frame_sync_o(frame_sync_o), .frame_start_o(frame_start_o),
        .cw_sync_o(cw_sync_o), .in_sync_o(in_sync_o)
    );

    function automatic bit code_on(int p, int start, int groups);
        int rel, b;
        if (p < start) return 1'b0;
        rel = p - start;
        if (rel >= groups * GP) return 1'b0;
        b = rel % GP;
        if (b >= BITS * BC) return 1'b0;
        return (b % BC) < BH;
    endfunction

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model of the frame phase, updated per edge.
    always @(posedge clk) begin
        bit act;
        if (!rst_n) begin
            mrun = 1'b1; mp = 0;
            e_fs = 0; e_st = 0; e_in = 0; e_cw = 0;
        end else begin
            act  = mrun && !stop_i;
            e_fs = act && (mp < SH);
            e_st = act && (mp == 0);
            e_in = act && code_on(mp, IN_ST, ING);
            e_cw = act && code_on(mp, CW_ST, CWG);
            if (stop_i) begin
                mrun = 1'b0; mp = 0;
            end else if (run_i && !mrun) begin
                mrun = 1'b1; mp = 0;
            end else if (mrun) begin
                mp = (mp == FR - 1) ? 0 : mp + 1;
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        check("R2 frame_sync", frame_sync_o, e_fs);
        check("R3 frame_start", frame_start_o, e_st);
        check("R5 in_sync", in_sync_o, e_in);
        check("R5 cw_sync", cw_sync_o, e_cw);
        check("R11 overlap", frame_sync_o && (in_sync_o || cw_sync_o), 1'b0);
    end

    task automatic wait_frame_start();
        do @(negedge clk); while (!frame_start_o);
    endtask

    // Measures one whole frame from a frame-start cycle.
    task automatic measure_frame();
        int n_in = 0, n_cw = 0, first_in = -1, in_last = -1, first_cw = -1;
        bit p_in = 1'b0, p_cw = 1'b0;
        wait_frame_start();
        for (int c = 0; c < FR; c++) begin
            if (c > 0) @(negedge clk);
            if (in_sync_o && !p_in) begin
                n_in++;
                if (n_in == 1) first_in = c;
                if (n_in == (ING - 1) * BITS + 1) in_last = c;
            end
            if (cw_sync_o && !p_cw) begin
                n_cw++;
                if (n_cw == 1) first_cw = c;
            end
            p_in = in_sync_o;
            p_cw = cw_sync_o;
        end
        check("R4 in first rise", first_in == IN_ST, 1'b1);
        check("R4 in rise count", n_in == ING * BITS, 1'b1);
        check("R6 cw rise count", n_cw == CWG * BITS, 1'b1);
        check("R6 cw aligned to last in group", first_cw == in_last, 1'b1);
        check("R6 cw first rise", first_cw == CW_ST, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int per;
        process::self().srandom(32'd1234);
        repeat (5) @(negedge clk);
        // R1: outputs low in reset.
        check("R1 reset quiet", frame_sync_o | frame_start_o | cw_sync_o | in_sync_o, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R2 auto start sync", frame_sync_o, 1'b1);
        check("R3 auto start strobe", frame_start_o, 1'b1);

        measure_frame();

        // R9: run while running leaves the period untouched.
        wait_frame_start();
        repeat (100) @(negedge clk);
        run_i = 1'b1;
        @(negedge clk);
        run_i = 1'b0;
        per = 101;
        while (!frame_start_o) begin @(negedge clk); per++; end
        check("R9 period after run while running", per == FR, 1'b1);

        // R7: stop silences outputs, mid instruction train.
        repeat (IN_ST + 5) @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            check("R7 stopped quiet", frame_sync_o | frame_start_o | cw_sync_o | in_sync_o, 1'b0);
            @(negedge clk);
        end

        // R8: restart latency.
        run_i = 1'b1;
        @(posedge clk); #1;
        check("R8 not yet high", frame_sync_o, 1'b0);
        @(negedge clk);
        run_i = 1'b0;
        @(posedge clk); #1;
        check("R8 sync after restart", frame_sync_o, 1'b1);
        check("R8 strobe after restart", frame_start_o, 1'b1);

        // R10: stop wins over run.
        repeat (300) @(negedge clk);
        stop_i = 1'b1; run_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0; run_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 stop priority", frame_sync_o | in_sync_o | cw_sync_o, 1'b0);
        run_i = 1'b1;
        @(negedge clk);
        run_i = 1'b0;

        measure_frame();

        // Random run/stop traffic checked by the model.
        for (int i = 0; i < 40000; i++) begin
            int r;
            @(negedge clk);
            r = $urandom % 5000;
            stop_i = (r < 2) || (r == 7);
            run_i  = (r >= 2 && r < 60) || (r == 7);
        end
        @(negedge clk);
        stop_i = 1'b0; run_i = 1'b1;
        @(negedge clk);
        run_i = 1'b0;
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule